// File: doc/BRIEF.md
# Test-Mode Signal Access Multiplexer

This block sits between a controller, a data path and the data path's primary pins. It lets a tester reach the internal control and status lines between the two parts without any new pins. Two mode pins choose the mode. With both low, the circuit runs normally. Status passes from the data path to the controller, control passes the other way, and the pins show the data path's own outputs. In controller test, the controller's status inputs come from the data path's primary input pins. Its control outputs appear on the primary output pins.

In data-path test, a per-cycle source select chooses what the output pins carry. It is either the data path's response or its status outputs, never both in one cycle. A small group of free test pins is forwarded only to the part under test, and a test-enable line to the data path is raised only in data-path test. The output pins are driven from a register, so every value reaches the pins one clock after the cycle it was selected in. Status and control widths are parameters no wider than the pin width. Unused upper pin bits read zero.

Top module: `tma_access_mux`

## Requirements
- R1: In every mode, `dp_ci` equals `ctl_co` and `dp_pi` equals `pin_in` in the same cycle.
- R2: Normal mode is `tp_ctl_mode`=0 and `tp_dp_mode`=0. In it, `ctl_si` equals `dp_so` in the same cycle, and `pin_out` after the next rising edge equals `dp_po` from the cycle before that edge.
- R3: Controller test is `tp_ctl_mode`=1 and `tp_dp_mode`=0. In it, `ctl_si` equals `pin_in[SW-1:0]` in the same cycle.
- R4: In controller test, `pin_out` after the next rising edge equals `ctl_co` in bits CW-1:0, with zeros above.
- R5: Data-path test is `tp_ctl_mode`=0 and `tp_dp_mode`=1. In it, `ctl_si` equals `dp_so`. After the next rising edge, `pin_out` equals `dp_po` if `obs_sel` was 0. If `obs_sel` was 1, it equals `dp_so` in bits SW-1:0 with zeros above.
- R6: `dp_dft_en` is 1 only in data-path test. `dp_aux` equals `tp_aux` in data-path test and is zero otherwise. `ctl_aux` equals `tp_aux` in controller test and is zero otherwise.
- R7: With both mode pins at 1, the block behaves exactly as in normal mode.
- R8: `obs_sel` has no effect on `pin_out` outside data-path test.
- R9: While `rst_n` is low, `pin_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output pin register |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_ctl_mode | input | 1 | Mode pin selecting controller test |
| tp_dp_mode | input | 1 | Mode pin selecting data-path test |
| tp_aux | input | AUX_W | Free test pins, forwarded to the part under test |
| obs_sel | input | 1 | Output source in data-path test: 0 response, 1 status |
| pin_in | input | PIN_W | Data-path primary input pins |
| pin_out | output | PIN_W | Data-path primary output pins (registered) |
| dp_pi | output | PIN_W | Primary inputs delivered to the data path |
| dp_po | input | PIN_W | Data response from the data path |
| ctl_co | input | CW | Control outputs of the controller |
| dp_ci | output | CW | Control inputs delivered to the data path |
| dp_so | input | SW | Status outputs of the data path |
| ctl_si | output | SW | Status inputs delivered to the controller |
| ctl_aux | output | AUX_W | Free test pins gated for the controller |
| dp_aux | output | AUX_W | Free test pins gated for the data path |
| dp_dft_en | output | 1 | Enables the data path's added test elements |

## Verification
A wrong mode decode shows at once on `ctl_si`, `ctl_aux`, `dp_aux` and `dp_dft_en`. It shows one clock later on `pin_out` as the wrong source, such as control bits in place of the response. A fault in the pin register or its padding shows on `pin_out` exactly one edge after the inputs that set it. The bench sweeps every mode pin pair and both select values over distinct input words, so each misroute shows within one cycle of its stimulus.

// File: rtl/tma_pkg.sv
package tma_pkg;

  typedef enum logic [1:0] {
    TMA_NORMAL   = 2'd0,
    TMA_CTL_TEST = 2'd1,
    TMA_DP_TEST  = 2'd2
  } tma_mode_e;

  // Exactly one mode pin high selects a test mode; anything else is normal.
  function automatic tma_mode_e tma_decode(input logic ctl_pin, input logic dp_pin);
    if (ctl_pin && !dp_pin)      return TMA_CTL_TEST;
    else if (dp_pin && !ctl_pin) return TMA_DP_TEST;
    else                         return TMA_NORMAL;
  endfunction

endpackage

// File: rtl/tma_mode_decode.sv
module tma_mode_decode
  import tma_pkg::*;
#(
  parameter int AUX_W = 2
) (
  input  logic             tp_ctl_mode,
  input  logic             tp_dp_mode,
  input  logic [AUX_W-1:0] tp_aux,
  output tma_mode_e        mode,
  output logic [AUX_W-1:0] ctl_aux,
  output logic [AUX_W-1:0] dp_aux,
  output logic             dp_dft_en
);

  logic ctl_on;
  logic dp_on;

  always_comb begin
    mode   = tma_decode(tp_ctl_mode, tp_dp_mode);
    ctl_on = (mode == TMA_CTL_TEST);
    dp_on  = (mode == TMA_DP_TEST);
  end

  assign dp_dft_en = dp_on;

  // Per-bit gating of the free test pins toward each side.
  for (genvar b = 0; b < AUX_W; b++) begin : g_aux
    assign ctl_aux[b] = tp_aux[b] & ctl_on;
    assign dp_aux[b]  = tp_aux[b] & dp_on;
  end

endmodule

// File: rtl/tma_status_mux.sv
module tma_status_mux
  import tma_pkg::*;
#(
  parameter int SW = 2
) (
  input  tma_mode_e     mode,
  input  logic [SW-1:0] pin_low,
  input  logic [SW-1:0] dp_so,
  output logic [SW-1:0] ctl_si
);

  always_comb begin
    if (mode == TMA_CTL_TEST) ctl_si = pin_low;
    else                      ctl_si = dp_so;
  end

endmodule

// File: rtl/tma_obs_path.sv
module tma_obs_path
  import tma_pkg::*;
#(
  parameter int PIN_W = 8,
  parameter int CW    = 4,
  parameter int SW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tma_mode_e        mode,
  input  logic             obs_sel,
  input  logic [PIN_W-1:0] dp_po,
  input  logic [CW-1:0]    ctl_co,
  input  logic [SW-1:0]    dp_so,
  output logic [PIN_W-1:0] pin_out
);

  logic [PIN_W-1:0] co_ext;
  logic [PIN_W-1:0] so_ext;
  logic [PIN_W-1:0] nxt;
  logic [PIN_W-1:0] pin_q;

  // Zero-pad the narrow internal lines up to the pin width.
  for (genvar b = 0; b < PIN_W; b++) begin : g_pad
    if (b < CW) begin : g_co
      assign co_ext[b] = ctl_co[b];
    end else begin : g_co_z
      assign co_ext[b] = 1'b0;
    end
    if (b < SW) begin : g_so
      assign so_ext[b] = dp_so[b];
    end else begin : g_so_z
      assign so_ext[b] = 1'b0;
    end
  end

  always_comb begin
    case (mode)
      TMA_CTL_TEST: nxt = co_ext;
      TMA_DP_TEST:  nxt = obs_sel ? so_ext : dp_po;
      default:      nxt = dp_po;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= nxt;
  end

  assign pin_out = pin_q;

endmodule

// File: rtl/tma_access_mux.sv
module tma_access_mux
  import tma_pkg::*;
#(
  parameter int PIN_W = 8,
  parameter int CW    = 4,
  parameter int SW    = 2,
  parameter int AUX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tp_ctl_mode,
  input  logic             tp_dp_mode,
  input  logic [AUX_W-1:0] tp_aux,
  input  logic             obs_sel,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] dp_pi,
  input  logic [PIN_W-1:0] dp_po,
  input  logic [CW-1:0]    ctl_co,
  output logic [CW-1:0]    dp_ci,
  input  logic [SW-1:0]    dp_so,
  output logic [SW-1:0]    ctl_si,
  output logic [AUX_W-1:0] ctl_aux,
  output logic [AUX_W-1:0] dp_aux,
  output logic             dp_dft_en
);

  tma_mode_e mode;

  // Primary inputs and control lines are never rerouted.
  assign dp_pi = pin_in;
  assign dp_ci = ctl_co;

  tma_mode_decode #(.AUX_W(AUX_W)) u_decode (
    .tp_ctl_mode (tp_ctl_mode),
    .tp_dp_mode  (tp_dp_mode),
    .tp_aux      (tp_aux),
    .mode        (mode),
    .ctl_aux     (ctl_aux),
    .dp_aux      (dp_aux),
    .dp_dft_en   (dp_dft_en)
  );

  tma_status_mux #(.SW(SW)) u_status (
    .mode    (mode),
    .pin_low (pin_in[SW-1:0]),
    .dp_so   (dp_so),
    .ctl_si  (ctl_si)
  );

  tma_obs_path #(.PIN_W(PIN_W), .CW(CW), .SW(SW)) u_obs (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .obs_sel (obs_sel),
    .dp_po   (dp_po),
    .ctl_co  (ctl_co),
    .dp_so   (dp_so),
    .pin_out (pin_out)
  );

endmodule

// File: rtl/tma_access_checks.sv
module tma_access_checks #(
  parameter int PIN_W = 8,
  parameter int CW    = 4,
  parameter int SW    = 2,
  parameter int AUX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tp_ctl_mode,
  input logic             tp_dp_mode,
  input logic [AUX_W-1:0] tp_aux,
  input logic             obs_sel,
  input logic [PIN_W-1:0] pin_in,
  input logic [PIN_W-1:0] pin_out,
  input logic [PIN_W-1:0] dp_pi,
  input logic [PIN_W-1:0] dp_po,
  input logic [CW-1:0]    ctl_co,
  input logic [CW-1:0]    dp_ci,
  input logic [SW-1:0]    dp_so,
  input logic [SW-1:0]    ctl_si,
  input logic [AUX_W-1:0] ctl_aux,
  input logic [AUX_W-1:0] dp_aux,
  input logic             dp_dft_en
);

  logic             in_ctl;
  logic             in_dp;
  logic [PIN_W-1:0] co_wide;
  logic [PIN_W-1:0] so_wide;

  assign in_ctl  = tp_ctl_mode && !tp_dp_mode;
  assign in_dp   = tp_dp_mode && !tp_ctl_mode;
  assign co_wide = PIN_W'(ctl_co);
  assign so_wide = PIN_W'(dp_so);

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_ci == ctl_co) && (dp_pi == pin_in));

  assert_status_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ctl |-> (ctl_si == dp_so));

  assert_out_normal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!in_ctl && !in_dp) |-> (pin_out == $past(dp_po)));

  assert_status_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ctl |-> (ctl_si == pin_in[SW-1:0]));

  assert_out_ctl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_ctl) |-> (pin_out == $past(co_wide)));

  assert_out_dp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(in_dp) |->
      (pin_out == ($past(obs_sel) ? $past(so_wide) : $past(dp_po))));

  assert_test_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_dft_en == in_dp) && (dp_aux == (in_dp ? tp_aux : '0)) &&
    (ctl_aux == (in_ctl ? tp_aux : '0)));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_R9: assert (pin_out == '0);
    end
  end

endmodule

bind tma_access_mux tma_access_checks #(
  .PIN_W(PIN_W), .CW(CW), .SW(SW), .AUX_W(AUX_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .tp_ctl_mode(tp_ctl_mode), .tp_dp_mode(tp_dp_mode),
  .tp_aux(tp_aux), .obs_sel(obs_sel), .pin_in(pin_in), .pin_out(pin_out),
  .dp_pi(dp_pi), .dp_po(dp_po), .ctl_co(ctl_co), .dp_ci(dp_ci), .dp_so(dp_so),
  .ctl_si(ctl_si), .ctl_aux(ctl_aux), .dp_aux(dp_aux), .dp_dft_en(dp_dft_en)
);

// File: tb/tb_tma_access_mux.sv
`timescale 1ns/1ps
module tb_tma_access_mux;

  localparam int PIN_W = 4;
  localparam int CW    = 3;
  localparam int SW    = 2;
  localparam int AUX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tp_ctl_mode, tp_dp_mode, obs_sel;
  logic [AUX_W-1:0] tp_aux;
  logic [PIN_W-1:0] pin_in, pin_out, dp_pi, dp_po;
  logic [CW-1:0]    ctl_co, dp_ci;
  logic [SW-1:0]    dp_so, ctl_si;
  logic [AUX_W-1:0] ctl_aux, dp_aux;
  logic             dp_dft_en;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tma_access_mux #(.PIN_W(PIN_W), .CW(CW), .SW(SW), .AUX_W(AUX_W)) dut (
    .clk(clk), .rst_n(rst_n), .tp_ctl_mode(tp_ctl_mode), .tp_dp_mode(tp_dp_mode),
    .tp_aux(tp_aux), .obs_sel(obs_sel), .pin_in(pin_in), .pin_out(pin_out),
    .dp_pi(dp_pi), .dp_po(dp_po), .ctl_co(ctl_co), .dp_ci(dp_ci), .dp_so(dp_so),
    .ctl_si(ctl_si), .ctl_aux(ctl_aux), .dp_aux(dp_aux), .dp_dft_en(dp_dft_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tp_ctl_mode = 0; tp_dp_mode = 0; obs_sel = 0;
    tp_aux = '0; pin_in = 4'd9; dp_po = 4'd13; ctl_co = 3'd5; dp_so = 2'd3;
    repeat (3) @(negedge clk);
    check("R9 reset pin_out", int'(pin_out), 0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < 16; i++) begin
          bit ctl_t, dp_t;
          int e_out, e_si;
          string otag;
          tp_ctl_mode = m[0];
          tp_dp_mode  = m[1];
          obs_sel     = s[0];
          tp_aux      = AUX_W'(i + m);
          pin_in      = PIN_W'(i);
          dp_po       = PIN_W'(i * 5 + 3);
          ctl_co      = CW'(i * 3 + 1);
          dp_so       = SW'(i + 2);
          ctl_t = (m == 1);
          dp_t  = (m == 2);
          #1;
          check("R1 dp_ci", int'(dp_ci), int'(ctl_co));
          check("R1 dp_pi", int'(dp_pi), i);
          e_si = ctl_t ? (i % 4) : ((i + 2) % 4);
          check(ctl_t ? "R3 ctl_si" : (m == 3 ? "R7 ctl_si" : "R2/R5 ctl_si"),
                int'(ctl_si), e_si);
          check("R6 dp_dft_en", int'(dp_dft_en), int'(dp_t));
          check("R6 dp_aux", int'(dp_aux), dp_t ? ((i + m) % 4) : 0);
          check("R6 ctl_aux", int'(ctl_aux), ctl_t ? ((i + m) % 4) : 0);
          if (ctl_t)            begin e_out = (i * 3 + 1) % 8; otag = "R4 pin_out"; end
          else if (dp_t && s)   begin e_out = (i + 2) % 4;     otag = "R5 pin_out status"; end
          else if (dp_t)        begin e_out = (i * 5 + 3) % 16; otag = "R5 pin_out response"; end
          else if (m == 3)      begin e_out = (i * 5 + 3) % 16; otag = "R7 pin_out"; end
          else                  begin e_out = (i * 5 + 3) % 16; otag = "R2 pin_out"; end
          if (!dp_t && s) otag = {otag, " R8"};
          @(posedge clk);
          @(negedge clk);
          check(otag, int'(pin_out), e_out);
        end
      end
    end

    // Reset asserted mid-run clears the pins at once.
    dp_po = 4'd15; tp_ctl_mode = 0; tp_dp_mode = 0;
    rst_n = 1'b0;
    #1;
    check("R9 async reset pin_out", int'(pin_out), 0);
    @(negedge clk);
    check("R9 held reset pin_out", int'(pin_out), 0);
    finish_run();
  end

endmodule